// File: doc/BRIEF.md
# Word-to-Tape Frame Formatter

This block sits between a 36-bit word datapath and a byte-wide tape channel. On the write side it takes a stream of 36-bit words and emits 8-bit tape frames. On the read side it takes 8-bit frames and rebuilds 36-bit words. A two-bit packing selector chooses one of four layouts:

- **dump**: five frames per word.
- **truncate**: four frames per word, with the low bits dropped.
- **text**: five frames per word, carrying five 7-bit characters plus one relocated bit.
- **dense**: nine frames per pair of words.

Both data paths use valid/ready streaming. A transfer happens on a rising clock edge where valid and ready are both high. A producer must hold its data, and its last flag, steady while valid is high and ready is low. Each direction stalls on back-pressure without dropping or repeating anything. A record is the run of items up to and including one that carries the last flag. The packing mode is captured at the first item of each record, separately in each direction.

Bit numbering: port bit 35 of a word is its first bit in tape order. Frame bit 7 holds the earliest word bit carried in that frame.

Top module: `tape_frame_fmt`

## Requirements
- R1: Dump mode (sel=0) writes each word as five frames. The first four frames are word bits [35:28], [27:20], [19:12] and [11:4]. The fifth frame is 4'b0000 followed by bits [3:0].
- R2: Truncate mode (sel=1) writes four frames, [35:28] down to [11:4], and drops bits [3:0]. On read, a word is rebuilt from four frames with bits [3:0] set to zero.
- R3: Text mode (sel=2) writes five frames. Frames one to four are a 0 followed by the 7-bit fields [35:29], [28:22], [21:15] and [14:8]. The fifth frame is bit [0] followed by field [7:1]. Reading inverts this mapping.
- R4: Dense mode (sel=3) writes a word pair A,B as nine frames:
  - four frames of A[35:4];
  - one shared frame {A[3:0], B[35:32]};
  - four frames of B[31:0].
  Reading rebuilds both words.
- R5: In dense mode, a record that ends on an unpaired word ends with the shared frame {A[3:0], 4'b0000}, which is marked last. On read, a last flag on the shared frame yields just the one word.
- R6: A dump-mode read ignores the upper nibble of the fifth frame.
- R7: The mode is captured at the first word (write) or first frame (read) of a record. A selector change inside a record has no effect until the record ends.
- R8: Under back-pressure, a stalled output keeps its valid, data and last flag steady. Every item is delivered exactly once.
- R9: The written frame stream marks the final frame of a record with out_frame_last. The read word stream marks the word completed by a last frame with out_word_last.
- R10: After reset, no output is valid and both input ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Packing mode: 0 dump, 1 truncate, 2 text, 3 dense |
| in_word_valid | input | 1 | Write word available |
| in_word_ready | output | 1 | Write word accepted when high with valid |
| in_word | input | 36 | Write word, bit 35 first |
| in_word_last | input | 1 | Write word ends its record |
| out_frame_valid | output | 1 | Tape frame available |
| out_frame_ready | input | 1 | Frame sink ready |
| out_frame | output | 8 | Tape frame |
| out_frame_last | output | 1 | Final frame of a record |
| in_frame_valid | input | 1 | Read frame available |
| in_frame_ready | output | 1 | Read frame accepted when high with valid |
| in_frame | input | 8 | Read frame |
| in_frame_last | input | 1 | Read frame ends its record |
| out_word_valid | output | 1 | Rebuilt word available |
| out_word_ready | input | 1 | Word sink ready |
| out_word | output | 36 | Rebuilt word |
| out_word_last | output | 1 | Rebuilt word ends its record |

## Verification
Each fault in the sequencing state shows up at the ports within one word group, which is at most nine frames:

- A frame index that slips shows up as rotated or misplaced bytes in the next frames.
- A mode latch that tracks the selector mid-record shows up as a change of layout partway through a record.
- A missed second-word wait in dense mode shows up as a shared frame carrying stale bits.

Back-pressure faults show up at once, as data changing under a stalled valid, or later as a surplus or a shortage of items when the expected stream is drained.

// File: rtl/tfmt_pkg.sv
package tfmt_pkg;
  localparam int WORD_W  = 36;
  localparam int FRAME_W = 8;
  localparam int IDX_W   = 4;

  typedef enum logic [1:0] {
    MODE_DUMP  = 2'd0,
    MODE_TRUNC = 2'd1,
    MODE_TEXT  = 2'd2,
    MODE_DENSE = 2'd3
  } pack_mode_e;

  // Byte k (0 = first in tape order) of the upper 32 bits of a word
  function automatic logic [FRAME_W-1:0] word_byte(input logic [WORD_W-1:0] w, input logic [1:0] k);
    case (k)
      2'd0:    return w[35:28];
      2'd1:    return w[27:20];
      2'd2:    return w[19:12];
      default: return w[11:4];
    endcase
  endfunction

  // Seven-bit field k of a word, first four fields
  function automatic logic [6:0] text_char(input logic [WORD_W-1:0] w, input logic [1:0] k);
    case (k)
      2'd0:    return w[35:29];
      2'd1:    return w[28:22];
      2'd2:    return w[21:15];
      default: return w[14:8];
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w, input logic [1:0] k,
                                                 input logic [FRAME_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    case (k)
      2'd0:    r[35:28] = b;
      2'd1:    r[27:20] = b;
      2'd2:    r[19:12] = b;
      default: r[11:4]  = b;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] put_char(input logic [WORD_W-1:0] w, input logic [1:0] k,
                                                 input logic [6:0] c);
    logic [WORD_W-1:0] r;
    r = w;
    case (k)
      2'd0:    r[35:29] = c;
      2'd1:    r[28:22] = c;
      2'd2:    r[21:15] = c;
      default: r[14:8]  = c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tfmt_packer.sv
module tfmt_packer
  import tfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               in_word_valid,
  output logic               in_word_ready,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_word_last,
  output logic               out_frame_valid,
  input  logic               out_frame_ready,
  output logic [FRAME_W-1:0] out_frame,
  output logic               out_frame_last
);
  logic              busy, rec_open, a_last, b_last, have_b;
  logic [IDX_W-1:0]  idx, last_idx, b_idx;
  logic [WORD_W-1:0] a_q, b_q;
  pack_mode_e        mode_q;
  logic              pair, wait_b, word_fire, frame_fire, at_end;

  // A pair is in flight in dense mode unless the first word closed the record
  assign pair     = (mode_q == MODE_DENSE) && !a_last;
  assign last_idx = (mode_q == MODE_TRUNC) ? 4'd3 : (pair ? 4'd8 : 4'd4);
  assign wait_b   = pair && !have_b && (idx == 4'd4);
  assign b_idx    = idx - 4'd5;
  assign at_end   = (idx == last_idx);

  assign out_frame_valid = busy && !wait_b;
  assign in_word_ready   = !busy || (pair && !have_b && (idx <= 4'd4));
  assign word_fire       = in_word_valid && in_word_ready;
  assign frame_fire      = out_frame_valid && out_frame_ready;
  assign out_frame_last  = at_end && (pair ? b_last : a_last);

  always_comb begin
    out_frame = word_byte(a_q, idx[1:0]);
    case (mode_q)
      MODE_DUMP:
        if (idx == 4'd4) out_frame = {4'b0000, a_q[3:0]};
      MODE_TEXT:
        if (idx == 4'd4) out_frame = {a_q[0], a_q[7:1]};
        else             out_frame = {1'b0, text_char(a_q, idx[1:0])};
      MODE_DENSE:
        if (idx == 4'd4)     out_frame = {a_q[3:0], pair ? b_q[35:32] : 4'b0000};
        else if (idx > 4'd4) out_frame = word_byte({b_q[31:0], 4'b0000}, b_idx[1:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rec_open <= 1'b0;
      a_last   <= 1'b0;
      b_last   <= 1'b0;
      have_b   <= 1'b0;
      idx      <= '0;
      a_q      <= '0;
      b_q      <= '0;
      mode_q   <= MODE_DUMP;
    end else begin
      if (word_fire) begin
        if (!busy) begin
          busy   <= 1'b1;
          idx    <= '0;
          a_q    <= in_word;
          a_last <= in_word_last;
          have_b <= 1'b0;
          if (!rec_open) begin
            mode_q   <= pack_mode_e'(mode_sel);
            rec_open <= 1'b1;
          end
        end else begin
          b_q    <= in_word;
          b_last <= in_word_last;
          have_b <= 1'b1;
        end
      end
      if (frame_fire) begin
        if (at_end) begin
          busy   <= 1'b0;
          have_b <= 1'b0;
          idx    <= '0;
          if (out_frame_last) rec_open <= 1'b0;
        end else begin
          idx <= idx + 4'd1;
        end
      end
    end
  end

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_valid && !out_frame_ready |=> out_frame_valid && $stable(out_frame) && $stable(out_frame_last));
  p_dump_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_valid && mode_q == MODE_DUMP && idx == 4'd4 |-> out_frame[7:4] == 4'b0000);
  p_text_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_valid && mode_q == MODE_TEXT && idx < 4'd4 |-> !out_frame[7]);
  p_odd_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_valid && mode_q == MODE_DENSE && a_last && idx == 4'd4 |-> out_frame[3:0] == 4'b0000 && out_frame_last);
  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 4'd8);
endmodule

// File: rtl/tfmt_unpacker.sv
module tfmt_unpacker
  import tfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               in_frame_valid,
  output logic               in_frame_ready,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               in_frame_last,
  output logic               out_word_valid,
  input  logic               out_word_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_word_last
);
  logic [IDX_W-1:0]  idx, b_idx;
  logic [WORD_W-1:0] asm_q, asm_d, word_c;
  pack_mode_e        mode_q, eff_mode;
  logic              rec_open, fire, complete, grp_end;

  assign eff_mode       = rec_open ? mode_q : pack_mode_e'(mode_sel);
  assign in_frame_ready = !out_word_valid || out_word_ready;
  assign fire           = in_frame_valid && in_frame_ready;
  assign b_idx          = idx - 4'd5;

  always_comb begin
    complete = 1'b0;
    grp_end  = 1'b0;
    word_c   = '0;
    asm_d    = asm_q;
    case (eff_mode)
      MODE_DUMP:
        if (idx == 4'd4) begin
          complete = 1'b1;
          grp_end  = 1'b1;
          word_c   = {asm_q[35:4], in_frame[3:0]};
        end else asm_d = put_byte(asm_q, idx[1:0], in_frame);
      MODE_TRUNC:
        if (idx == 4'd3) begin
          complete = 1'b1;
          grp_end  = 1'b1;
          word_c   = {asm_q[35:12], in_frame, 4'b0000};
        end else asm_d = put_byte(asm_q, idx[1:0], in_frame);
      MODE_TEXT:
        if (idx == 4'd4) begin
          complete = 1'b1;
          grp_end  = 1'b1;
          word_c   = {asm_q[35:8], in_frame[6:0], in_frame[7]};
        end else asm_d = put_char(asm_q, idx[1:0], in_frame[6:0]);
      default: begin
        if (idx < 4'd4) asm_d = put_byte(asm_q, idx[1:0], in_frame);
        else if (idx == 4'd4) begin
          complete      = 1'b1;
          grp_end       = in_frame_last;
          word_c        = {asm_q[35:4], in_frame[7:4]};
          asm_d[35:32]  = in_frame[3:0];
        end else if (idx == 4'd8) begin
          complete = 1'b1;
          grp_end  = 1'b1;
          word_c   = {asm_q[35:8], in_frame};
        end else begin
          asm_d = put_byte({asm_q[31:0], asm_q[35:32]}, b_idx[1:0], in_frame);
          asm_d = {asm_d[3:0], asm_d[35:4]};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx            <= '0;
      asm_q          <= '0;
      mode_q         <= MODE_DUMP;
      rec_open       <= 1'b0;
      out_word_valid <= 1'b0;
      out_word       <= '0;
      out_word_last  <= 1'b0;
    end else begin
      if (out_word_valid && out_word_ready) out_word_valid <= 1'b0;
      if (fire) begin
        asm_q <= asm_d;
        if (!rec_open) begin
          mode_q   <= eff_mode;
          rec_open <= 1'b1;
        end
        if (complete) begin
          out_word_valid <= 1'b1;
          out_word       <= word_c;
          out_word_last  <= in_frame_last;
        end
        if (in_frame_last) begin
          rec_open <= 1'b0;
          idx      <= '0;
        end else if (grp_end) idx <= '0;
        else                  idx <= idx + 4'd1;
      end
    end
  end

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_word_valid && !out_word_ready |=> out_word_valid && $stable(out_word) && $stable(out_word_last));
  p_trunc_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_word_valid && mode_q == MODE_TRUNC |-> out_word[3:0] == 4'b0000);
  p_stall_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_word_valid && !out_word_ready |-> !in_frame_ready);
endmodule

// File: rtl/tape_frame_fmt.sv
module tape_frame_fmt
  import tfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               in_word_valid,
  output logic               in_word_ready,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_word_last,
  output logic               out_frame_valid,
  input  logic               out_frame_ready,
  output logic [FRAME_W-1:0] out_frame,
  output logic               out_frame_last,
  input  logic               in_frame_valid,
  output logic               in_frame_ready,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               in_frame_last,
  output logic               out_word_valid,
  input  logic               out_word_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_word_last
);
  tfmt_packer u_pack (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_word_valid(in_word_valid), .in_word_ready(in_word_ready),
    .in_word(in_word), .in_word_last(in_word_last),
    .out_frame_valid(out_frame_valid), .out_frame_ready(out_frame_ready),
    .out_frame(out_frame), .out_frame_last(out_frame_last)
  );

  tfmt_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_frame_valid(in_frame_valid), .in_frame_ready(in_frame_ready),
    .in_frame(in_frame), .in_frame_last(in_frame_last),
    .out_word_valid(out_word_valid), .out_word_ready(out_word_ready),
    .out_word(out_word), .out_word_last(out_word_last)
  );
endmodule

// File: tb/tb_tape_frame_fmt.sv
module tb_tape_frame_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        in_word_valid = 1'b0, in_word_last = 1'b0;
  logic [35:0] in_word = '0;
  logic        in_word_ready;
  logic        out_frame_valid, out_frame_last;
  logic        out_frame_ready = 1'b0;
  logic [7:0]  out_frame;
  logic        in_frame_valid = 1'b0, in_frame_last = 1'b0;
  logic [7:0]  in_frame = '0;
  logic        in_frame_ready;
  logic        out_word_valid, out_word_last;
  logic        out_word_ready = 1'b0;
  logic [35:0] out_word;

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R10";
  logic [35:0] wl [0:15];
  logic [8:0]  exp_f [$];
  logic [36:0] exp_w [$];
  logic [8:0]  built [$];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_frame_fmt dut (.*);

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Ready generators for the two sinks: mostly ready, frequent stalls (R8)
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_frame_ready <= lfsr[0] | lfsr[3];
    out_word_ready  <= lfsr[5] | lfsr[8];
  end

  // Frame monitor (write side scoreboard)
  bit f_stall = 0; logic [8:0] f_prev;
  always @(negedge clk) if (rst_n) begin
    if (f_stall) check(out_frame_valid && {out_frame_last, out_frame} == f_prev, "R8",
                       "frame held under stall", {out_frame_last, out_frame}, f_prev);
    f_stall = out_frame_valid && !out_frame_ready;
    f_prev  = {out_frame_last, out_frame};
    if (out_frame_valid && out_frame_ready) begin
      if (exp_f.size() == 0) check(0, "R8", "unexpected frame", {out_frame_last, out_frame}, 0);
      else begin
        logic [8:0] e;
        e = exp_f.pop_front();
        check({out_frame_last, out_frame} == e, tag, "frame {last,data} (R9)", {out_frame_last, out_frame}, e);
      end
    end
  end

  // Word monitor (read side scoreboard)
  bit w_stall = 0; logic [36:0] w_prev;
  always @(negedge clk) if (rst_n) begin
    if (w_stall) check(out_word_valid && {out_word_last, out_word} == w_prev, "R8",
                       "word held under stall", {out_word_last, out_word}, w_prev);
    w_stall = out_word_valid && !out_word_ready;
    w_prev  = {out_word_last, out_word};
    if (out_word_valid && out_word_ready) begin
      if (exp_w.size() == 0) check(0, "R8", "unexpected word", {out_word_last, out_word}, 0);
      else begin
        logic [36:0] e;
        e = exp_w.pop_front();
        check({out_word_last, out_word} == e, tag, "word {last,data} (R9)", {out_word_last, out_word}, e);
      end
    end
  end

  // Bench model: build the tape bit stream in tape order and cut into frames
  task automatic build_frames(input int md, input int n, input bit junk);
    bit bq[$];
    built.delete();
    for (int i = 0; i < n; i++) begin
      logic [35:0] w;
      w = wl[i];
      case (md)
        0: begin
          for (int b = 0; b < 32; b++) bq.push_back(w[35-b]);
          for (int b = 0; b < 4; b++) bq.push_back(junk ? (b % 2 == 0) : 1'b0);
          for (int b = 32; b < 36; b++) bq.push_back(w[35-b]);
        end
        1: for (int b = 0; b < 32; b++) bq.push_back(w[35-b]);
        2: begin
          for (int c = 0; c < 4; c++) begin
            bq.push_back(1'b0);
            for (int b = 0; b < 7; b++) bq.push_back(w[35-(7*c+b)]);
          end
          bq.push_back(w[0]);
          for (int b = 28; b < 35; b++) bq.push_back(w[35-b]);
        end
        default: begin
          for (int b = 0; b < 36; b++) bq.push_back(w[35-b]);
          if (i % 2 == 0 && i == n-1) for (int b = 0; b < 4; b++) bq.push_back(1'b0);
        end
      endcase
      while (bq.size() >= 8) begin
        logic [7:0] f;
        for (int b = 0; b < 8; b++) f[7-b] = bq.pop_front();
        built.push_back({1'b0, f});
      end
    end
    built[built.size()-1][8] = 1'b1;
  endtask

  task automatic fill_words(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [31:0] m;
      m = (i + seed * 7) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
      wl[i] = {m[31:28] ^ 4'h9, m};
    end
  endtask

  task automatic send_word(input logic [35:0] w, input bit last);
    in_word = w; in_word_last = last; in_word_valid = 1'b1;
    do @(negedge clk); while (!in_word_ready);
    @(posedge clk); #1;
    in_word_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] f);
    in_frame = f[7:0]; in_frame_last = f[8]; in_frame_valid = 1'b1;
    do @(negedge clk); while (!in_frame_ready);
    @(posedge clk); #1;
    in_frame_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_f.size() != 0 || exp_w.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Write test: selector flipped after the first word (R7)
  task automatic write_rec(input int md, input int n, input string t);
    tag = t;
    build_frames(md, n, 0);
    foreach (built[k]) exp_f.push_back(built[k]);
    mode_sel = md[1:0];
    for (int i = 0; i < n; i++) begin
      send_word(wl[i], i == n-1);
      mode_sel = md[1:0] ^ 2'b01;
    end
    drain();
  endtask

  // Read test: selector flipped after the first frame (R7)
  task automatic read_rec(input int md, input int n, input string t);
    tag = t;
    build_frames(md, n, md == 0);
    for (int i = 0; i < n; i++)
      exp_w.push_back({i == n-1, (md == 1) ? (wl[i] & ~36'hF) : wl[i]});
    mode_sel = md[1:0];
    foreach (built[k]) begin
      send_frame(built[k]);
      mode_sel = md[1:0] ^ 2'b10;
    end
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!out_frame_valid && !out_word_valid, "R10", "outputs idle", {out_frame_valid, out_word_valid}, 0);
    check(in_word_ready && in_frame_ready, "R10", "inputs ready", {in_word_ready, in_frame_ready}, 2'b11);
    @(posedge clk); #1;

    fill_words(3, 1); wl[0] = '1;          write_rec(0, 3, "R1/R7");
    fill_words(2, 2);                      write_rec(1, 2, "R2");
    fill_words(3, 3); wl[1] = 36'h0_0000_0001; write_rec(2, 3, "R3");
    fill_words(4, 4);                      write_rec(3, 4, "R4/R7");
    fill_words(3, 5);                      write_rec(3, 3, "R5");
    fill_words(1, 6); wl[0] = 36'hF_0000_000F; write_rec(3, 1, "R5");
    fill_words(2, 7);                      write_rec(2, 1, "R3/R9");

    fill_words(3, 8); wl[2] = '1;          read_rec(0, 3, "R6/R1");
    fill_words(2, 9);                      read_rec(1, 2, "R2/R7");
    fill_words(3, 10);                     read_rec(2, 3, "R3");
    fill_words(4, 11);                     read_rec(3, 4, "R4");
    fill_words(3, 12);                     read_rec(3, 3, "R5/R9");

    check(exp_f.size() == 0 && exp_w.size() == 0, "R8", "nothing lost", exp_f.size() + exp_w.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule